// File: doc/BRIEF.md
# Valid-Gated Command Collector and Sequence Dispatcher

This block gathers a 5-bit command from a set of requesters without any high-impedance logic. Each requester presents a command word and an enable line. An AND-OR selector places the chosen word on one shared, fully driven command signal, and a command-valid flag is formed as the OR of all enables. Consumers read that single signal. No consumer ever compares it against a floating value.

A dispatcher state machine watches the valid flag. While the flag is low it waits in its idle state. When the flag is high it decodes the command and starts one of three step chains: a read chain, a pixel update chain (a read step followed by the write steps) or a plain write chain. Every chain ends in idle with a one-cycle completion pulse. The command is latched when the machine leaves idle, so traffic on the shared signal cannot disturb a chain that is already running. If more than one enable is high at once, an error flag is raised and the lowest-numbered requester wins.

Top module: `cmd_dispatch_top`

## Requirements
- R1: `cmd_o` always carries a known 0/1 value. When no enable is high, `cmd_o` is all zeros.
- R2: `cmd_valid_o` equals the OR of all bits of `req_en_i` in the same cycle.
- R3: With one enable high, `cmd_o` equals that requester's word (requester i occupies bits [5i+4:5i] of `req_cmd_i`). With several high, `cmd_o` takes the lowest-indexed enabled requester's word and `multi_err_o` is 1 in the same cycle. Otherwise `multi_err_o` is 0.
- R4: In idle (state code 0), with `cmd_valid_o` low, the next state is idle whatever the command bits hold.
- R5: In idle, a valid command equal to 5'b00000 (no-op) keeps the machine in idle and produces no done pulse.
- R6: In idle, a valid command with bit 4 set moves through read step 1 (code 1), then read step 2 (code 2), then back to idle.
- R7: In idle, a valid command equal to 5'b00001 (set-pixel) moves through pixel read (code 3), write setup 1 (code 4), write setup 2 (code 5), then back to idle.
- R8: In idle, any other valid command with bit 4 clear moves through codes 4 and 5, then back to idle.
- R9: `done_o` is high for exactly one cycle: the first idle cycle after code 2 or code 5.
- R10: `cmd_q_o` loads `cmd_o` on the clock edge that leaves idle, and holds that value until the next such edge, whatever the bus does.
- R11: A synchronous active-high `rst` sets the state to 0, `done_o` to 0 and `cmd_q_o` to 0, including in the middle of a chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_cmd_i | input | N_REQ*5 | Packed command words, requester i at bits [5i+4:5i] |
| req_en_i | input | N_REQ | Per-requester enable |
| cmd_o | output | 5 | Selected shared command |
| cmd_valid_o | output | 1 | OR of all enables |
| multi_err_o | output | 1 | More than one enable high |
| state_o | output | 3 | Dispatcher state code |
| cmd_q_o | output | 5 | Command latched at chain start |
| done_o | output | 1 | One-cycle chain completion pulse |

## Verification
The assertions check on every cycle that the bus holds a known value and follows the lowest-index rule. They also check that the error flag follows the enable count, that idle holds when the flag is low or the command is a no-op, that each step leads to its successor, that done lasts one cycle, and that the latched command stays stable during a chain. Other behaviour can only be shown by the bench's scenarios: which chain each of the 32 codes selects end to end, how the machine restarts back-to-back while an enable stays high, how it recovers from a reset in the middle of a chain, and what it does when the bus changes while a chain runs.

// File: rtl/cmdbus_pkg.sv
package cmdbus_pkg;

  localparam int unsigned STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'd0,
    ST_RD1  = 3'd1,
    ST_RD2  = 3'd2,
    ST_PXR  = 3'd3,
    ST_WS1  = 3'd4,
    ST_WS2  = 3'd5
  } seq_state_t;

  // Successor of a non-idle step; idle maps to itself.
  function automatic seq_state_t step_after(input seq_state_t s);
    case (s)
      ST_RD1:  return ST_RD2;
      ST_PXR:  return ST_WS1;
      ST_WS1:  return ST_WS2;
      default: return ST_IDLE;
    endcase
  endfunction

  // True for the final step of any chain.
  function automatic logic is_last_step(input seq_state_t s);
    return (s == ST_RD2) || (s == ST_WS2);
  endfunction

endpackage

// File: rtl/cmd_mux.sv
module cmd_mux #(
  parameter int unsigned N_REQ = 4,
  parameter int unsigned CMD_W = 5
) (
  input  logic [N_REQ*CMD_W-1:0] req_cmd_i,
  input  logic [N_REQ-1:0]       req_en_i,
  output logic [CMD_W-1:0]       cmd_o,
  output logic                   valid_o,
  output logic                   multi_o
);

  // Isolate the lowest set enable bit: one-hot grant.
  function automatic logic [N_REQ-1:0] lowest_one(input logic [N_REQ-1:0] v);
    return v & (~v + {{(N_REQ-1){1'b0}}, 1'b1});
  endfunction

  logic [N_REQ-1:0] grant;
  logic [CMD_W-1:0] gated [N_REQ];

  assign grant = lowest_one(req_en_i);

  genvar gi;
  generate
    for (gi = 0; gi < N_REQ; gi++) begin : g_and
      assign gated[gi] = req_cmd_i[gi*CMD_W +: CMD_W] & {CMD_W{grant[gi]}};
    end
  endgenerate

  always_comb begin
    cmd_o = '0;
    for (int i = 0; i < N_REQ; i++) begin
      cmd_o = cmd_o | gated[i];
    end
  end

  assign valid_o = |req_en_i;
  assign multi_o = |(req_en_i & ~grant);

endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmdbus_pkg::*;
#(
  parameter int unsigned      CMD_W    = 5,
  parameter logic [CMD_W-1:0] NOP_CODE = '0,
  parameter logic [CMD_W-1:0] PIX_CODE = 1
) (
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             valid_i,
  output seq_state_t       first_o,
  output logic             start_o
);

  localparam int unsigned RD_BIT = CMD_W - 1;

  // Priority order matters: no-op, then read bit, then set-pixel, then write.
  function automatic seq_state_t classify(input logic [CMD_W-1:0] c);
    if (c == NOP_CODE)   return ST_IDLE;
    else if (c[RD_BIT])  return ST_RD1;
    else if (c == PIX_CODE) return ST_PXR;
    else                 return ST_WS1;
  endfunction

  assign first_o = valid_i ? classify(cmd_i) : ST_IDLE;
  assign start_o = (first_o != ST_IDLE);

endmodule

// File: rtl/cmd_seq.sv
module cmd_seq
  import cmdbus_pkg::*;
#(
  parameter int unsigned CMD_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  seq_state_t       first_i,
  input  logic             start_i,
  input  logic [CMD_W-1:0] cmd_i,
  output seq_state_t       state_o,
  output logic [CMD_W-1:0] cmd_q_o,
  output logic             done_o
);

  seq_state_t state_q, state_d;

  always_comb begin
    if (state_q == ST_IDLE) state_d = first_i;
    else                    state_d = step_after(state_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cmd_q_o <= '0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= is_last_step(state_q);
      if (state_q == ST_IDLE && start_i) cmd_q_o <= cmd_i;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/cmd_dispatch_top.sv
module cmd_dispatch_top
  import cmdbus_pkg::*;
#(
  parameter int unsigned      N_REQ    = 4,
  parameter int unsigned      CMD_W    = 5,
  parameter logic [CMD_W-1:0] NOP_CODE = 5'b00000,
  parameter logic [CMD_W-1:0] PIX_CODE = 5'b00001
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_REQ*CMD_W-1:0] req_cmd_i,
  input  logic [N_REQ-1:0]       req_en_i,
  output logic [CMD_W-1:0]       cmd_o,
  output logic                   cmd_valid_o,
  output logic                   multi_err_o,
  output logic [STATE_W-1:0]     state_o,
  output logic [CMD_W-1:0]       cmd_q_o,
  output logic                   done_o
);

  seq_state_t first_st;
  seq_state_t cur_st;
  logic       start_w;

  cmd_mux #(.N_REQ(N_REQ), .CMD_W(CMD_W)) u_mux (
    .req_cmd_i (req_cmd_i),
    .req_en_i  (req_en_i),
    .cmd_o     (cmd_o),
    .valid_o   (cmd_valid_o),
    .multi_o   (multi_err_o)
  );

  cmd_decode #(.CMD_W(CMD_W), .NOP_CODE(NOP_CODE), .PIX_CODE(PIX_CODE)) u_dec (
    .cmd_i   (cmd_o),
    .valid_i (cmd_valid_o),
    .first_o (first_st),
    .start_o (start_w)
  );

  cmd_seq #(.CMD_W(CMD_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .first_i (first_st),
    .start_i (start_w),
    .cmd_i   (cmd_o),
    .state_o (cur_st),
    .cmd_q_o (cmd_q_o),
    .done_o  (done_o)
  );

  assign state_o = cur_st;

endmodule

// File: rtl/cmd_dispatch_chk.sv
module cmd_dispatch_chk #(
  parameter int unsigned      N_REQ    = 4,
  parameter int unsigned      CMD_W    = 5,
  parameter logic [CMD_W-1:0] NOP_CODE = 5'b00000,
  parameter logic [CMD_W-1:0] PIX_CODE = 5'b00001
) (
  input logic                   clk,
  input logic                   rst,
  input logic [N_REQ*CMD_W-1:0] req_cmd_i,
  input logic [N_REQ-1:0]       req_en_i,
  input logic [CMD_W-1:0]       cmd_o,
  input logic                   cmd_valid_o,
  input logic                   multi_err_o,
  input logic [2:0]             state_o,
  input logic [CMD_W-1:0]       cmd_q_o,
  input logic                   done_o
);

  p_known_bus_r1: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(cmd_o));

  p_valid_or_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o == (req_en_i != '0));

  p_lowest_wins_r3: assert property (@(posedge clk) disable iff (rst)
    req_en_i[0] |-> cmd_o == req_cmd_i[CMD_W-1:0]);

  p_multi_flag_r3: assert property (@(posedge clk) disable iff (rst)
    multi_err_o == ($countones(req_en_i) > 1));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd0 && !cmd_valid_o) |=> state_o == 3'd0);

  p_nop_r5: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd0 && cmd_valid_o && cmd_o == NOP_CODE) |=> state_o == 3'd0);

  p_read_entry_r6: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd0 && cmd_valid_o && cmd_o[CMD_W-1]) |=> state_o == 3'd1);

  p_read_step_r6: assert property (@(posedge clk) disable iff (rst)
    state_o == 3'd1 |=> state_o == 3'd2);

  p_pix_entry_r7: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd0 && cmd_valid_o && cmd_o == PIX_CODE) |=> state_o == 3'd3);

  p_pix_step_r7: assert property (@(posedge clk) disable iff (rst)
    state_o == 3'd3 |=> state_o == 3'd4);

  p_write_step_r8: assert property (@(posedge clk) disable iff (rst)
    state_o == 3'd4 |=> state_o == 3'd5);

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd2 || state_o == 3'd5) |=> (done_o && state_o == 3'd0));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_hold_cmd_r10: assert property (@(posedge clk) disable iff (rst)
    (state_o != 3'd0) |=> (state_o == 3'd0 || $stable(cmd_q_o)));

endmodule

bind cmd_dispatch_top cmd_dispatch_chk #(
  .N_REQ(N_REQ), .CMD_W(CMD_W), .NOP_CODE(NOP_CODE), .PIX_CODE(PIX_CODE)
) u_chk (
  .clk(clk), .rst(rst), .req_cmd_i(req_cmd_i), .req_en_i(req_en_i),
  .cmd_o(cmd_o), .cmd_valid_o(cmd_valid_o), .multi_err_o(multi_err_o),
  .state_o(state_o), .cmd_q_o(cmd_q_o), .done_o(done_o)
);

// File: tb/cmd_dispatch_top_tb.sv
module cmd_dispatch_top_tb;

  localparam int NR = 4;
  localparam int CW = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NR*CW-1:0] req_cmd = '0;
  logic [NR-1:0]   req_en = '0;
  logic [CW-1:0]   cmd_o;
  logic            cmd_valid_o;
  logic            multi_err_o;
  logic [2:0]      state_o;
  logic [CW-1:0]   cmd_q_o;
  logic            done_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // reference model state
  int       m_state = 0;
  int       m_done  = 0;
  int       m_cq    = 0;

  always #5 clk = ~clk;

  cmd_dispatch_top u_dut (
    .clk(clk), .rst(rst), .req_cmd_i(req_cmd), .req_en_i(req_en),
    .cmd_o(cmd_o), .cmd_valid_o(cmd_valid_o), .multi_err_o(multi_err_o),
    .state_o(state_o), .cmd_q_o(cmd_q_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock: apply inputs, check the selector, step model, check registers.
  task automatic cyc(input logic r, input logic [NR-1:0] en,
                     input logic [NR*CW-1:0] cmds, input string tag);
    int ecmd;
    int cnt;
    int nxt;
    rst = r; req_en = en; req_cmd = cmds;
    #1;
    ecmd = 0; cnt = 0;
    for (int i = NR-1; i >= 0; i--) begin
      if (en[i]) begin
        ecmd = int'(cmds[i*CW +: CW]);
        cnt++;
      end
    end
    chk("R1 bus known", int'($isunknown(cmd_o)), 0);
    chk("R3 bus value", int'(cmd_o), ecmd);
    chk("R2 valid", int'(cmd_valid_o), (cnt > 0) ? 1 : 0);
    chk("R3 multi flag", int'(multi_err_o), (cnt > 1) ? 1 : 0);
    @(posedge clk);
    if (r) begin
      m_state = 0; m_done = 0; m_cq = 0;
    end else begin
      m_done = (m_state == 2 || m_state == 5) ? 1 : 0;
      nxt = 0;
      if (m_state == 0) begin
        if (cnt > 0 && ecmd != 0) begin
          if (ecmd >= 16)     nxt = 1;
          else if (ecmd == 1) nxt = 3;
          else                nxt = 4;
          m_cq = ecmd;
        end
      end else if (m_state == 1) nxt = 2;
      else if (m_state == 3) nxt = 4;
      else if (m_state == 4) nxt = 5;
      m_state = nxt;
    end
    @(negedge clk);
    chk({tag, " state"}, int'(state_o), m_state);
    chk("R9 done", int'(done_o), m_done);
    chk("R10 latched cmd", int'(cmd_q_o), m_cq);
  endtask

  function automatic logic [NR*CW-1:0] put(input int idx, input logic [CW-1:0] c,
                                           input logic [NR*CW-1:0] base);
    logic [NR*CW-1:0] v;
    v = base;
    v[idx*CW +: CW] = c;
    return v;
  endfunction

  initial begin
    @(negedge clk);
    cyc(1'b1, '0, '0, "R11");
    chk("R11 reset state", int'(state_o), 0);
    chk("R11 reset done", int'(done_o), 0);
    chk("R11 reset cmdq", int'(cmd_q_o), 0);

    // R1, R4: no enable, garbage on the inputs
    for (int k = 0; k < 4; k++) cyc(1'b0, '0, 20'hFBCDE ^ (k * 20'h1357), "R4");

    // R6: read from requester 2, bus changes during chain (R10)
    cyc(1'b0, 4'b0100, put(2, 5'b10110, '0), "R6");
    cyc(1'b0, 4'b0001, put(0, 5'b00111, '0), "R6");
    cyc(1'b0, 4'b1000, put(3, 5'b11111, '0), "R6");
    cyc(1'b0, '0, '0, "R6");
    cyc(1'b0, '0, '0, "R6");

    // R7: set-pixel from requester 1
    cyc(1'b0, 4'b0010, put(1, 5'b00001, '0), "R7");
    for (int k = 0; k < 4; k++) cyc(1'b0, '0, '0, "R7");

    // R8: plain write from requester 3
    cyc(1'b0, 4'b1000, put(3, 5'b00110, '0), "R8");
    for (int k = 0; k < 3; k++) cyc(1'b0, '0, '0, "R8");

    // R5: no-op held valid
    for (int k = 0; k < 3; k++) cyc(1'b0, 4'b0100, put(2, 5'b00000, 20'hFFFFF), "R5");

    // R3: several enables, lowest wins
    cyc(1'b0, 4'b0110, put(1, 5'b00001, put(2, 5'b10000, '0)), "R3");
    for (int k = 0; k < 4; k++) cyc(1'b0, 4'b1100, put(2, 5'b01010, put(3, 5'b10101, '0)), "R3");
    for (int k = 0; k < 4; k++) cyc(1'b0, '0, '0, "R3");

    // back-to-back: enable held high restarts chains
    for (int k = 0; k < 8; k++) cyc(1'b0, 4'b0001, put(0, 5'b11001, '0), "R6");
    for (int k = 0; k < 3; k++) cyc(1'b0, '0, '0, "R6");

    // R11: reset in the middle of a chain
    cyc(1'b0, 4'b0001, put(0, 5'b00001, '0), "R11");
    cyc(1'b0, '0, '0, "R11");
    cyc(1'b1, 4'b0001, put(0, 5'b10001, '0), "R11");
    cyc(1'b0, '0, '0, "R11");

    // sweep every code through requester 0
    for (int c = 0; c < 32; c++) begin
      cyc(1'b0, 4'b0001, put(0, c[CW-1:0], 20'hAAAAA), "R8 sweep");
      for (int k = 0; k < 4; k++) cyc(1'b0, '0, '0, "R6 sweep");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule